// File: doc/BRIEF.md
# Status Reporting Group with Edge Filter

This block is one level of a status reporting tree in a test instrument. A 16-bit live status vector enters on `cond_i`. Two programmable masks pick, for each bit, whether a rising edge, a falling edge, both or neither is worth recording. Recorded edges latch into an event register. The event bits are gated by an enable mask and ORed into one summary bit, `summary_o`, which is meant to drive one condition input of the parent group.

A host reaches the registers through a small port with single-cycle strobes. Read data is combinational in the strobe cycle. Reading the event register empties it on the following clock edge. A global clear input also empties the event register. Only bits 1 and 2 are implemented: bit 1 flags the first arm layer and bit 2 flags the second (scan) layer. Every other bit reads as 0.

Top module: `stat_group`

## Requirements
- R1: A read at address 0 returns `cond_i` masked to bits 1 and 2 in the same cycle, with no latching.
- R2: When an implemented condition bit goes from 0 to 1 between two clock edges, the event bit sets at the second edge if its rise-mask bit is 1.
- R3: When a condition bit goes from 1 to 0, the event bit sets if its fall-mask bit is 1. With both mask bits set, either edge sets it. With neither set, no edge sets it.
- R4: An event bit stays set until it is cleared, even if the condition returns to its earlier level.
- R5: A read at address 1 returns the event register, and the register clears on the next clock edge. An edge recorded in that same cycle survives the clear.
- R6: `clear_i` high at a clock edge clears the event register and leaves the enable, rise and fall masks unchanged.
- R7: `summary_o` is 1 exactly when some event bit and its enable bit are both 1. It follows the registers with no further delay.
- R8: Addresses 2, 3 and 4 hold the enable, rise and fall masks. Each is written by `wr_i` and left unchanged by reads. After reset they read 0x0000, 0x0006 and 0x0000.
- R9: Bits other than 1 and 2 read as 0 in every register, and addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cond_i | input | 16 | Live status condition vector |
| clear_i | input | 1 | Global clear of the event register |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| summary_o | output | 1 | Enabled-event summary to the parent group |

## Verification
The condition bits are driven with isolated rises, isolated falls and rise-then-fall pulses. These are run under rise-only, fall-only, both-edge and no-edge mask settings, which separates each edge direction from the others and a latched event from a live level. Directed cases put an event read, or a global clear, in the same cycle as a new edge, which shows whether the new edge wins. Enable patterns with masked and unmasked set events show whether the summary gating is correct. Random traffic mixes all of these with writes, reads of every address and toggles on unused bits.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;
  typedef enum logic [AW-1:0] {
    A_COND = 3'd0,
    A_EVT  = 3'd1,
    A_EN   = 3'd2,
    A_RISE = 3'd3,
    A_FALL = 3'd4
  } addr_e;
endpackage

// File: rtl/stat_edge.sv
module stat_edge #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = 16'h0006
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] cond_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i & IMPL;

  always_comb
    set_o = (((cond_i & ~cond_q) & rise_en_i) |
             ((~cond_i & cond_q) & fall_en_i)) & IMPL;
endmodule

// File: rtl/stat_event.sv
module stat_event #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = 16'h0006
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       evt_o[b] <= 1'b0;
        else if (set_i[b]) evt_o[b] <= 1'b1;  // new edge beats clear
        else if (clr_i)    evt_o[b] <= 1'b0;
    end else begin : g_tie
      assign evt_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/stat_regs.sv
module stat_regs
  import stat_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = 16'h0006
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_o   <= '0;
      rise_o <= IMPL;
      fall_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_EN:    en_o   <= wdata_i & IMPL;
        A_RISE:  rise_o <= wdata_i & IMPL;
        A_FALL:  fall_o <= wdata_i & IMPL;
        default: ;
      endcase
    end
endmodule

// File: rtl/stat_group.sv
module stat_group
  import stat_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter logic [W-1:0] IMPL = 16'h0006
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  cond_i,
  input  logic          clear_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          summary_o
);
  logic [W-1:0] set_vec, evt_q, en_q, rise_q, fall_q;
  logic         evt_clr;

  stat_regs #(.W(W), .IMPL(IMPL)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .en_o(en_q), .rise_o(rise_q), .fall_o(fall_q)
  );

  stat_edge #(.W(W), .IMPL(IMPL)) u_edge (
    .clk_i, .rst_ni, .cond_i,
    .rise_en_i(rise_q), .fall_en_i(fall_q), .set_o(set_vec)
  );

  assign evt_clr = clear_i | (rd_i & (addr_i == A_EVT));

  stat_event #(.W(W), .IMPL(IMPL)) u_evt (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(evt_clr), .evt_o(evt_q)
  );

  assign summary_o = |(evt_q & en_q);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_COND:  rdata_o = cond_i & IMPL;
        A_EVT:   rdata_o = evt_q;
        A_EN:    rdata_o = en_q;
        A_RISE:  rdata_o = rise_q;
        A_FALL:  rdata_o = fall_q;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk
  import stat_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] IMPL = 16'h0006
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  rdata_o,
  input logic [W-1:0]  set_vec,
  input logic [W-1:0]  evt_q,
  input logic [W-1:0]  en_q
);
  logic rd_evt;
  assign rd_evt = rd_i && (addr_i == A_EVT);

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  // R4
  evt_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !rd_evt) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R5
  rd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && set_vec == '0) |=> (evt_q == '0));

  // R6
  en_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_EN) |=> $stable(en_q));

  // R9
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o & ~IMPL) == '0));
endmodule

bind stat_group stat_group_chk #(.W(W), .IMPL(IMPL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .rd_i(rd_i),
  .wr_i(wr_i), .addr_i(addr_i), .rdata_o(rdata_o), .set_vec(set_vec),
  .evt_q(evt_q), .en_q(en_q)
);

// File: tb/stat_group_bench.sv
module stat_group_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IMP = 16'h0006;

  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] cond_i = 0, wdata_i = 0;
  logic        clear_i = 0, rd_i = 0, wr_i = 0;
  logic [2:0]  addr_i = 0;
  logic [15:0] rdata_o;
  logic        summary_o;

  int checks = 0, fails = 0;
  logic [15:0] m_prev, m_evt, m_en, m_rise, m_fall;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stat_group u_stat_group (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [2:0] a, input logic [15:0] c);
    case (a)
      3'd0: return c & IMP;
      3'd1: return m_evt;
      3'd2: return m_en;
      3'd3: return m_rise;
      3'd4: return m_fall;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] m_set(input logic [15:0] c);
    logic [15:0] cm;
    cm = c & IMP;
    return ((cm & ~m_prev & m_rise) | (~cm & m_prev & m_fall)) & IMP;
  endfunction

  // one cycle: drive at negedge, check read before the edge, model the edge
  task automatic cyc(input logic rd, input logic wr, input logic [2:0] a,
                     input logic [15:0] wd, input logic [15:0] c, input logic clr,
                     input string req = "R1");
    logic [15:0] s;
    @(negedge clk_i);
    chk("R7 summary", {15'd0, summary_o}, {15'd0, |(m_evt & m_en)});
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd; cond_i = c; clear_i = clr;
    #1;
    if (rd) chk(req, rdata_o, m_read(a, c));
    @(posedge clk_i);
    s = m_set(c);
    m_evt = (clr || (rd && a == 3'd1)) ? s : (m_evt | s);
    if (wr) case (a)
      3'd2: m_en = wd & IMP;
      3'd3: m_rise = wd & IMP;
      3'd4: m_fall = wd & IMP;
      default: ;
    endcase
    m_prev = c & IMP;
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cyc(1, 0, a, 0, cond_i, 0, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(0, 1, a, d, cond_i, 0);
  endtask

  task automatic setc(input logic [15:0] c);
    cyc(0, 0, 0, 0, c, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_prev = 0; m_evt = 0; m_en = 0; m_rise = IMP; m_fall = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R8 reset defaults
    rd(3'd2, "R8 en reset");
    rd(3'd3, "R8 rise reset");
    rd(3'd4, "R8 fall reset");
    rd(3'd1, "R5 evt reset");
    // R1 live condition, R9 unused bits
    setc(16'hFFFF); rd(3'd0, "R1 cond live");
    setc(16'h8001); rd(3'd0, "R9 cond unused");
    rd(3'd1, "R2 rise evt");
    setc(16'h0000);
    // R2 rise with enable off, summary stays low (R7)
    setc(16'h0002);
    setc(16'h0000);
    rd(3'd2, "R8 en not changed by read");
    chk("R7 masked summary", {15'd0, summary_o}, 16'd0);
    wr(3'd2, 16'hFFFF); rd(3'd2, "R9 en masked");
    rd(3'd1, "R4 latched after return");
    rd(3'd1, "R5 cleared by read");
    // R3 fall only
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0006);
    setc(16'h0004); rd(3'd1, "R3 rise ignored");
    setc(16'h0000); rd(3'd1, "R3 fall sets");
    // R3 both
    wr(3'd3, 16'h0006);
    setc(16'h0002); rd(3'd1, "R3 both rise");
    setc(16'h0000); rd(3'd1, "R3 both fall");
    // R3 neither
    wr(3'd3, 0); wr(3'd4, 0);
    setc(16'h0006); setc(16'h0000); rd(3'd1, "R3 neither");
    // R5 read same cycle as new edge
    wr(3'd3, 16'h0006);
    cyc(1, 0, 3'd1, 0, 16'h0002, 0, "R5 read with edge");
    rd(3'd1, "R5 edge survives");
    // R6 clear keeps masks
    setc(16'h0006);
    cyc(0, 0, 0, 0, 16'h0006, 1);
    rd(3'd1, "R6 cleared");
    rd(3'd2, "R6 en kept");
    rd(3'd3, "R6 rise kept");
    rd(3'd5, "R9 addr5");
    rd(3'd7, "R9 addr7");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] a;
      logic [15:0] c;
      int op;
      op = $urandom_range(0, 9);
      a = 3'($urandom_range(0, 7));
      c = 16'($urandom());
      if (op < 4)      cyc(1, 0, a, 0, c, 0, "R1 rand read");
      else if (op < 6) cyc(0, 1, a, 16'($urandom()), c, 0);
      else if (op < 7) cyc(0, 0, 0, 0, c, 1);
      else             cyc(0, 0, 0, 0, c, 0);
    end
    @(negedge clk_i);
    chk("R7 final summary", {15'd0, summary_o}, {15'd0, |(m_evt & m_en)});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule